// File: doc/BRIEF.md
# Integer to Single-Precision Converter

This block turns a 16-bit integer into a 32-bit single-precision floating-point word. A flag chosen per request selects whether the integer is read as two's complement or as unsigned. In two's complement mode a negative value is first replaced by its magnitude. The magnitude is then normalized by a loop that moves it left by one bit per clock. Each move lowers the exponent by one, starting from the exponent that fits a leading one in the top input bit. When the leading one reaches the top of the working register, that bit is dropped as the hidden one. The remaining bits are placed at the top of the fraction field, and the bias is already part of the exponent. A 16-bit value always fits exactly in the fraction, so no rounding takes place.

Requests arrive on a valid/ready input stream and results leave on a valid/ready output stream. The block takes one request at a time. `in_ready` is high only while the block is idle, and a request is taken on a clock edge where both `in_valid` and `in_ready` are high. A result is presented with `out_valid` and stays unchanged until the consumer raises `out_ready`. The block applies back-pressure to the input by keeping `in_ready` low until the result has been taken.

A separate combinational classifier is built into the same block. It examines any 32-bit single-precision word and reports which of five classes the word belongs to: zero, denormal, infinity, NaN or normal.

Top module: `int16_to_sp_conv`

## Requirements
- R1: `out_word` is laid out with the sign in bit 31, the biased exponent in bits 30:23 and the fraction in bits 22:0. The leading one of the normalized magnitude is not stored.
- R2: For a nonzero magnitude whose highest set bit is at position p, the exponent field is p + 127. Unsigned input 0x2A3B gives 0x4628EC00, which is exponent 140 (1000_1100) and fraction 0101000111011 followed by zeros.
- R3: The magnitude bits below the leading one are left-aligned in the fraction field, and every lower fraction bit is 0.
- R4: An input of zero, in either mode, gives the word 0x00000000.
- R5: When `in_signed`=1 and input bit 15 is 1, the sign bit is 1 and the magnitude is the two's complement negation of the input, so -32768 (0x8000) gives 0xC7000000. When `in_signed`=0 the sign bit is 0, so 0xFFFF gives 0x477FFF00.
- R6: After reset `in_ready` is 1, `out_valid` is 0 and `busy` is 0. A request is taken only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only while neither `busy` nor `out_valid` is 1.
- R7: Counted in rising edges from the edge that takes the request, `out_valid` is first high after 1 edge for a zero magnitude. For a nonzero magnitude it is first high after 2 + z edges, where z is the number of leading zero bits of the 16-bit magnitude. The most this can be is 17 edges. `busy` is 1 throughout the normalization cycles.
- R8: While `out_valid`=1 and `out_ready`=0, both `out_valid` and `out_word` hold. On an edge where both are 1, the result is consumed: on the next cycle `out_valid` is 0 and `in_ready` is 1.
- R9: Changes on `in_value`, `in_signed` and `in_valid` while `in_ready`=0 have no effect on the result being produced.
- R10: When bits 30:23 of `cls_word` are all ones, the classifier raises `cls_inf` if bits 22:0 are zero and raises `cls_nan` otherwise.
- R11: When bits 30:23 of `cls_word` are all zeros, the classifier raises `cls_zero` if bits 22:0 are zero and raises `cls_denorm` otherwise.
- R12: For any other exponent field the classifier raises `cls_normal`. Exactly one of the five class flags is high for every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A request is present on the input stream |
| in_ready | output | 1 | The block can take a request |
| in_signed | input | 1 | 1 reads the value as two's complement, 0 as unsigned |
| in_value | input | 16 | Integer to convert |
| busy | output | 1 | Normalization is in progress |
| out_valid | output | 1 | The result word is available |
| out_ready | input | 1 | The consumer takes the result |
| out_word | output | 32 | Single-precision result |
| cls_word | input | 32 | Word to classify |
| cls_zero | output | 1 | The word is zero |
| cls_denorm | output | 1 | The word is denormal |
| cls_inf | output | 1 | The word is infinity |
| cls_nan | output | 1 | The word is NaN |
| cls_normal | output | 1 | The word is a normal number |

## Verification
The assertions assume that reset is applied before the first request. They put no limit on how the producer and the consumer behave: `out_ready` and `in_valid` may be held high or low for any length of time, and `in_value` may change on any cycle, including during a conversion. The assertions also place no restriction on `cls_word`, because the class checks hold for every possible 32-bit pattern. The bench changes every input only at falling edges, holds `out_ready` low for several cycles to exercise back-pressure, and drives conflicting requests while the block is busy.

// File: rtl/sp_conv_pkg.sv
package sp_conv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_DONE = 2'd2
  } conv_state_t;

  typedef struct packed {
    logic zero;
    logic denorm;
    logic inf;
    logic nan;
    logic normal;
  } fp_class_t;

endpackage

// File: rtl/sp_mag_extract.sv
module sp_mag_extract #(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0] value,
  input  logic            as_signed,
  output logic [IN_W-1:0] magnitude,
  output logic            negative
);
  // Negation of the most negative value wraps to 2^(IN_W-1), which is its magnitude read as unsigned.
  always_comb begin
    negative  = as_signed & value[IN_W-1];
    magnitude = negative ? (~value + 1'b1) : value;
  end
endmodule

// File: rtl/sp_normalizer.sv
module sp_normalizer
  import sp_conv_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int BIAS  = 127
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [IN_W-1:0]            load_mag,
  input  logic                       load_neg,
  input  logic                       take,
  output logic                       idle,
  output logic                       busy,
  output logic                       valid,
  output logic [EXP_W+MAN_W:0]       word
);
  localparam int WORD_W    = 1 + EXP_W + MAN_W;
  localparam int START_EXP = IN_W - 1 + BIAS;
  localparam int PAD_W     = MAN_W - (IN_W - 1);

  conv_state_t        state_q;
  logic [IN_W-1:0]    work_q;
  logic [EXP_W-1:0]   exp_q;
  logic               neg_q;
  logic [WORD_W-1:0]  word_q;
  logic [MAN_W-1:0]   frac;

  // Place the bits below the leading one at the top of the fraction field.
  generate
    if (PAD_W > 0) begin : g_pad
      assign frac = {work_q[IN_W-2:0], {PAD_W{1'b0}}};
    end else begin : g_exact
      assign frac = work_q[IN_W-2:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      work_q  <= '0;
      exp_q   <= '0;
      neg_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (load) begin
            work_q <= load_mag;
            neg_q  <= load_neg;
            exp_q  <= EXP_W'(START_EXP);
            if (load_mag == '0) begin
              word_q  <= '0;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_NORM;
            end
          end
        end
        ST_NORM: begin
          if (work_q[IN_W-1]) begin
            word_q  <= {neg_q, exp_q, frac};
            state_q <= ST_DONE;
          end else begin
            work_q <= work_q << 1;
            exp_q  <= exp_q - 1'b1;
          end
        end
        ST_DONE: begin
          if (take) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle  = (state_q == ST_IDLE);
  assign busy  = (state_q == ST_NORM);
  assign valid = (state_q == ST_DONE);
  assign word  = word_q;
endmodule

// File: rtl/sp_classifier.sv
module sp_classifier
  import sp_conv_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output fp_class_t            cls
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones, exp_zeros, man_zero;

  always_comb begin
    exp_f     = word[EXP_W+MAN_W-1:MAN_W];
    man_f     = word[MAN_W-1:0];
    exp_ones  = &exp_f;
    exp_zeros = ~|exp_f;
    man_zero  = ~|man_f;
    cls.zero   = exp_zeros & man_zero;
    cls.denorm = exp_zeros & ~man_zero;
    cls.inf    = exp_ones & man_zero;
    cls.nan    = exp_ones & ~man_zero;
    cls.normal = ~exp_zeros & ~exp_ones;
  end

  // Sign bit does not affect the class.
  logic unused_sign;
  assign unused_sign = word[EXP_W+MAN_W];
endmodule

// File: rtl/int16_to_sp_conv.sv
module int16_to_sp_conv
  import sp_conv_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int BIAS  = 127
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_signed,
  input  logic [IN_W-1:0]        in_value,
  output logic                   busy,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [EXP_W+MAN_W:0]   out_word,
  input  logic [EXP_W+MAN_W:0]   cls_word,
  output logic                   cls_zero,
  output logic                   cls_denorm,
  output logic                   cls_inf,
  output logic                   cls_nan,
  output logic                   cls_normal
);
  logic [IN_W-1:0] mag;
  logic            neg;
  logic            idle;
  fp_class_t       cls;

  sp_mag_extract #(.IN_W(IN_W)) u_mag (
    .value     (in_value),
    .as_signed (in_signed),
    .magnitude (mag),
    .negative  (neg)
  );

  sp_normalizer #(
    .IN_W(IN_W), .EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)
  ) u_norm (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_valid & idle),
    .load_mag (mag),
    .load_neg (neg),
    .take     (out_ready),
    .idle     (idle),
    .busy     (busy),
    .valid    (out_valid),
    .word     (out_word)
  );

  sp_classifier #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .word (cls_word),
    .cls  (cls)
  );

  assign in_ready   = idle;
  assign cls_zero   = cls.zero;
  assign cls_denorm = cls.denorm;
  assign cls_inf    = cls.inf;
  assign cls_nan    = cls.nan;
  assign cls_normal = cls.normal;
endmodule

// File: rtl/int16_to_sp_conv_chk.sv
module int16_to_sp_conv_chk #(
  parameter int IN_W  = 16,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int BIAS  = 127
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 in_signed,
  input logic [IN_W-1:0]      in_value,
  input logic                 busy,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [EXP_W+MAN_W:0] out_word,
  input logic [EXP_W+MAN_W:0] cls_word,
  input logic                 cls_zero,
  input logic                 cls_denorm,
  input logic                 cls_inf,
  input logic                 cls_nan,
  input logic                 cls_normal
);
  localparam int CNT_W = $clog2(IN_W + 3);
  localparam int W_MSB = EXP_W + MAN_W;

  logic             accept;
  logic             cap_signed, cap_zero;
  logic [CNT_W-1:0] lat_cnt;
  logic [EXP_W-1:0] out_exp;

  assign accept  = in_valid & in_ready;
  assign out_exp = out_word[W_MSB-1:MAN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_signed <= 1'b0;
      cap_zero   <= 1'b0;
      lat_cnt    <= '0;
    end else if (accept) begin
      cap_signed <= in_signed;
      cap_zero   <= (in_value == '0);
      lat_cnt    <= '0;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || out_valid) |-> !in_ready);

  assert_latency_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_cnt <= CNT_W'(IN_W));

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  assert_consume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  assert_exp_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cap_zero) |->
      (out_exp >= EXP_W'(BIAS) && out_exp <= EXP_W'(BIAS + IN_W - 1)));

  assert_zero_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_zero) |-> (out_word == '0));

  assert_unsigned_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cap_signed) |-> !out_word[W_MSB]);

  assert_top_exp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&cls_word[W_MSB-1:MAN_W]) |-> (cls_inf || cls_nan));

  assert_low_exp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (~|cls_word[W_MSB-1:MAN_W]) |-> (cls_zero || cls_denorm));

  assert_one_class_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cls_zero, cls_denorm, cls_inf, cls_nan, cls_normal}) == 1);
endmodule

bind int16_to_sp_conv int16_to_sp_conv_chk #(
  .IN_W(IN_W), .EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_signed(in_signed), .in_value(in_value), .busy(busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
  .cls_word(cls_word), .cls_zero(cls_zero), .cls_denorm(cls_denorm),
  .cls_inf(cls_inf), .cls_nan(cls_nan), .cls_normal(cls_normal)
);

// File: tb/int16_to_sp_conv_tb.sv
`timescale 1ns/1ps
module int16_to_sp_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_signed = 1'b0;
  logic [15:0] in_value = '0;
  logic        out_ready = 1'b0;
  logic [31:0] cls_word = '0;
  logic        in_ready, busy, out_valid;
  logic [31:0] out_word;
  logic        cls_zero, cls_denorm, cls_inf, cls_nan, cls_normal;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  int16_to_sp_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_signed(in_signed), .in_value(in_value), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .cls_word(cls_word), .cls_zero(cls_zero), .cls_denorm(cls_denorm),
    .cls_inf(cls_inf), .cls_nan(cls_nan), .cls_normal(cls_normal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Independent model: locate highest set bit, then shift into the fraction.
  function automatic logic [31:0] model_word(input logic [15:0] v, input logic s);
    logic        neg;
    logic [15:0] m;
    logic [31:0] t;
    int          p;
    neg = s & v[15];
    m   = neg ? 16'(-int'({16'd0, v})) : v;
    if (m == 16'd0) return 32'd0;
    p = 0;
    for (int i = 0; i < 16; i++) if (m[i]) p = i;
    t = 32'(m) << (23 - p);
    return {neg, 8'(p + 127), t[22:0]};
  endfunction

  function automatic int model_lat(input logic [15:0] v, input logic s);
    logic [15:0] m;
    int          p;
    m = (s & v[15]) ? 16'(-int'({16'd0, v})) : v;
    if (m == 16'd0) return 1;
    p = 0;
    for (int i = 0; i < 16; i++) if (m[i]) p = i;
    return 2 + (15 - p);
  endfunction

  // Send a request, wait for the result, check it and consume it.
  task automatic run_conv(input logic [15:0] v, input logic s, input logic [31:0] exp_word,
                          input string tag);
    int lat;
    @(negedge clk);
    in_value = v; in_signed = s; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " word"}, out_word, exp_word);
    chk("R7 latency", 32'(lat), 32'(model_lat(v, s)));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8 consumed", {30'd0, out_valid, in_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R6 reset state", {29'd0, in_ready, out_valid, busy}, 32'd4);
  endtask

  task automatic t_layout;
    run_conv(16'h2A3B, 1'b0, 32'h4628EC00, "R2 0x2A3B");
    run_conv(16'h0001, 1'b0, 32'h3F800000, "R1 one");
    run_conv(16'h8000, 1'b0, 32'h47000000, "R1 0x8000 unsigned");
    run_conv(16'h0005, 1'b0, 32'h40A00000, "R3 five");
    run_conv(16'h1234, 1'b0, model_word(16'h1234, 1'b0), "R3 0x1234");
  endtask

  task automatic t_signs;
    run_conv(16'h8000, 1'b1, 32'hC7000000, "R5 -32768");
    run_conv(16'hFFFF, 1'b0, 32'h477FFF00, "R5 0xFFFF unsigned");
    run_conv(16'hFFFF, 1'b1, 32'hBF800000, "R5 -1");
    run_conv(16'h7FFF, 1'b1, model_word(16'h7FFF, 1'b1), "R5 +32767");
    run_conv(16'hD5C5, 1'b1, model_word(16'hD5C5, 1'b1), "R5 negative");
  endtask

  task automatic t_zero;
    run_conv(16'h0000, 1'b0, 32'h00000000, "R4 zero unsigned");
    run_conv(16'h0000, 1'b1, 32'h00000000, "R4 zero signed");
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 16; k++) begin
      logic [15:0] v;
      v = (16'h0001 << k) | (16'h0001 << (k / 2));
      run_conv(v, k[0], model_word(v, k[0]), "R7 sweep");
    end
  endtask

  task automatic t_backpressure;
    logic [31:0] first;
    @(negedge clk);
    in_value = 16'h0300; in_signed = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    first = out_word;
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R8 held valid", {31'd0, out_valid}, 32'd1);
    chk("R8 held word", out_word, first);
    chk("R8 held word value", out_word, model_word(16'h0300, 1'b0));
    chk("R6 ready low while holding", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8 released", {30'd0, out_valid, in_ready}, 32'd1);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    in_value = 16'h0001; in_signed = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R7 busy during shift", {31'd0, busy}, 32'd1);
    in_value = 16'hFFFF; in_signed = 1'b1;
    for (int i = 0; i < 6; i++) @(negedge clk);
    in_value = 16'h4000; in_signed = 1'b0;
    while (!out_valid) @(negedge clk);
    in_valid = 1'b0;
    chk("R9 request ignored while busy", out_word, 32'h3F800000);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 no extra result", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic cls_chk(input logic [31:0] w, input logic [4:0] exp_flags, input string tag);
    @(negedge clk);
    cls_word = w;
    #1;
    chk(tag, {27'd0, cls_zero, cls_denorm, cls_inf, cls_nan, cls_normal}, {27'd0, exp_flags});
  endtask

  // Flag order: zero, denorm, inf, nan, normal.
  task automatic t_classify;
    cls_chk(32'h7F800000, 5'b00100, "R10 +inf");
    cls_chk(32'hFF800000, 5'b00100, "R10 -inf");
    cls_chk(32'h7FC00000, 5'b00010, "R10 nan");
    cls_chk(32'h7F800001, 5'b00010, "R10 nan low bit");
    cls_chk(32'h00000000, 5'b10000, "R11 zero");
    cls_chk(32'h80000000, 5'b10000, "R11 negative zero");
    cls_chk(32'h00000001, 5'b01000, "R11 denormal");
    cls_chk(32'h807FFFFF, 5'b01000, "R11 denormal max");
    cls_chk(32'h3F800000, 5'b00001, "R12 one");
    cls_chk(32'h00800000, 5'b00001, "R12 smallest normal");
    cls_chk(32'h7F7FFFFF, 5'b00001, "R12 largest normal");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_signs();
        t_zero();
        t_sweep();
        t_backpressure();
        t_ignore();
        t_classify();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule